// File: doc/BRIEF.md
# Flash Chip Erase Sequencer

This block runs a complete chip erase on a byte-wide flash device, from the host side of the flash bus. After a start pulse it raises the high-voltage supply enable. It then programs every byte to 00h, using a program/verify loop that allows a bounded number of program pulses per byte. Once every byte reads 00h, it issues erase pulses and checks the bytes one at a time in ascending order. Each byte must read FFh.

When a byte fails its check, the sequencer fires one more erase pulse and checks the same byte again. Bytes that have already passed are not checked again. A single counter limits the number of erase pulses for the whole chip. At the end the sequencer returns the device to plain read mode, drops the supply enable and raises `done`. `err_code` gives the outcome and `pulse_count` gives the number of erase pulses spent.

All analog waits are counts of clock cycles set by parameters. The device answers each read strobe with a data-valid pulse.

Top module: `flash_chip_eraser`

## Requirements
- R1: After reset, `supply_en`, `done`, `bus_wr` and `bus_rd` are 0, `err_code` is 0 and `pulse_count` is 0.
- R2: A `start` pulse raises `supply_en` before the first bus write. Every bus write is issued while `supply_en` is 1. `supply_en` is 0 when `done` rises.
- R3: Pre-programming walks the addresses in ascending order. For each address it writes 40h, then writes 00h to that address, then writes C0h and reads the byte. A byte is accepted when it reads 00h. No 20h write happens before every byte has been accepted.
- R4: If a byte still does not read 00h after `PROG_MAX` program pulses, the block ends with `err_code` = 1 (pre-program fault) and `pulse_count` = 0, and never writes 20h.
- R5: One erase pulse is two back-to-back writes of 20h. The next bus action comes at least `T_ERASE` cycles after the second write.
- R6: Erase verify writes A0h with the address under test on `bus_addr`. At least `T_VERIFY` cycles later it reads that address. A result of FFh moves on to the next address without a new pulse. The same minimum gap also applies between C0h and its read.
- R7: A byte that does not read FFh causes a new erase pulse, and the next verify uses the same address. Verified addresses never go backwards.
- R8: `pulse_count` equals the number of erase pulses issued. On success this is the largest number of pulses any byte needed.
- R9: If a byte fails verify after the `ERASE_MAX`-th pulse, the block ends with `err_code` = 2 (erase fault) and `pulse_count` = `ERASE_MAX`. It never issues more than `ERASE_MAX` pulses.
- R10: On success the last bus write is 00h. After it, `supply_en` drops and `done` rises with `err_code` = 0, and every byte reads FFh.
- R11: If the last byte passes on exactly the `ERASE_MAX`-th pulse, the run counts as a success, not an erase fault.
- R12: After the 00h program data write, at least `T_PROG` cycles pass before the C0h write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chip erase (sampled while idle) |
| bus_addr | output | ADDR_W | Flash byte address |
| bus_wdata | output | 8 | Command or data byte for a write |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data from the flash |
| bus_rvalid | input | 1 | Read data valid |
| supply_en | output | 1 | High-voltage supply enable |
| done | output | 1 | Run finished; held until the next start |
| err_code | output | 2 | 0 ok, 1 pre-program fault, 2 erase fault |
| pulse_count | output | $clog2(ERASE_MAX+1) | Erase pulses issued |

## Verification
Two events can fall on the same verify read: the last address passing, and the pulse counter reaching its limit. The outcome then depends on which of the two wins. The bench provokes this with a flash model in which only the last byte needs exactly `ERASE_MAX` pulses, which must give a success with the full count. It then repeats the run with that byte needing one pulse more, which must give an erase fault with no extra pulse. A byte in the middle that needs more than the limit, and a byte that needs exactly `PROG_MAX` or one more program pulse, probe the same kind of boundary in the other loops.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_PROG_VFY  = 8'hC0;
  localparam logic [7:0] BYTE_ZERO     = 8'h00;
  localparam logic [7:0] BYTE_BLANK    = 8'hFF;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_PREPROG = 2'd1,
    FAULT_ERASE   = 2'd2
  } fce_fault_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PSET, S_PDAT, S_PWAIT, S_PVC, S_PVW, S_PRD,
    S_ESET1, S_ESET2, S_EWAIT, S_EVC, S_EVW, S_ERD,
    S_RDMODE, S_FIN
  } fce_state_t;
endpackage

// File: rtl/fce_timer.sv
module fce_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5/R6/R12: a loaded non-zero wait is never reported as expired right away
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (load && val != '0) |=> !zero);
endmodule

// File: rtl/fce_counter.sv
module fce_counter #(
  parameter int MAX = 25,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_max = (cnt == W'(MAX));

  // R9: the sequencer never asks for a pulse beyond the limit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    !(inc && at_max));
endmodule

// File: rtl/fce_addr_seq.sv
module fce_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (inc)   addr <= addr + 1'b1;
  end

  assign last = &addr;

  // R7: the address moves forward by exactly one, never wraps from the top
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    !(inc && last));
  p_step_one_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/flash_chip_eraser.sv
module flash_chip_eraser #(
  parameter int ADDR_W    = 18,
  parameter int PROG_MAX  = 25,
  parameter int ERASE_MAX = 1000,
  parameter int T_PROG    = 1000,
  parameter int T_ERASE   = 1000000,
  parameter int T_VERIFY  = 600,
  parameter int PC_W      = $clog2(ERASE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_rvalid,
  output logic              supply_en,
  output logic              done,
  output logic [1:0]        err_code,
  output logic [PC_W-1:0]   pulse_count
);
  import fce_pkg::*;

  localparam int T_PV   = (T_PROG > T_VERIFY) ? T_PROG : T_VERIFY;
  localparam int T_MAXV = (T_ERASE > T_PV) ? T_ERASE : T_PV;
  localparam int TW     = $clog2(T_MAXV + 1);
  localparam int PPW    = $clog2(PROG_MAX + 1);

  fce_state_t st;
  fce_fault_t fault;

  logic              addr_clr, addr_inc, addr_last;
  logic [ADDR_W-1:0] addr;
  logic              ppc_clr, ppc_inc, ppc_max;
  logic [PPW-1:0]    ppc_cnt;
  logic              epc_clr, epc_inc, epc_max;
  logic              t_load, t_zero;
  logic [TW-1:0]     t_val;
  logic              rd_zero, rd_blank;

  assign rd_zero  = (bus_rdata == BYTE_ZERO);
  assign rd_blank = (bus_rdata == BYTE_BLANK);

  fce_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .clr(addr_clr), .inc(addr_inc),
    .addr(addr), .last(addr_last)
  );

  fce_counter #(.MAX(PROG_MAX), .W(PPW)) u_prog_cnt (
    .clk(clk), .rst(rst), .clr(ppc_clr), .inc(ppc_inc),
    .cnt(ppc_cnt), .at_max(ppc_max)
  );

  fce_counter #(.MAX(ERASE_MAX), .W(PC_W)) u_erase_cnt (
    .clk(clk), .rst(rst), .clr(epc_clr), .inc(epc_inc),
    .cnt(pulse_count), .at_max(epc_max)
  );

  fce_timer #(.W(TW)) u_wait (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .zero(t_zero)
  );

  // control strobes for the counters and the wait timer
  always_comb begin
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    ppc_clr  = 1'b0;
    ppc_inc  = 1'b0;
    epc_clr  = 1'b0;
    epc_inc  = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    unique case (st)
      S_IDLE: if (start) begin
        addr_clr = 1'b1;
        ppc_clr  = 1'b1;
        epc_clr  = 1'b1;
      end
      S_PDAT: begin
        ppc_inc = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(T_PROG);
      end
      S_PVC, S_EVC: begin
        t_load = 1'b1;
        t_val  = TW'(T_VERIFY);
      end
      S_PRD: if (bus_rvalid && rd_zero) begin
        ppc_clr = 1'b1;
        if (addr_last) addr_clr = 1'b1;
        else           addr_inc = 1'b1;
      end
      S_ESET2: begin
        epc_inc = 1'b1;
        t_load  = 1'b1;
        t_val   = TW'(T_ERASE);
      end
      S_ERD: if (bus_rvalid && rd_blank && !addr_last) addr_inc = 1'b1;
      default: ;
    endcase
  end

  // sequencer with registered bus and status outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      fault     <= FAULT_NONE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      supply_en <= 1'b0;
      done      <= 1'b0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          supply_en <= 1'b1;
          done      <= 1'b0;
          fault     <= FAULT_NONE;
          st        <= S_PSET;
        end
        S_PSET: begin
          bus_wr    <= 1'b1;
          bus_wdata <= CMD_PROG;
          st        <= S_PDAT;
        end
        S_PDAT: begin
          bus_wr    <= 1'b1;
          bus_wdata <= BYTE_ZERO;
          bus_addr  <= addr;
          st        <= S_PWAIT;
        end
        S_PWAIT: if (t_zero) st <= S_PVC;
        S_PVC: begin
          bus_wr    <= 1'b1;
          bus_wdata <= CMD_PROG_VFY;
          st        <= S_PVW;
        end
        S_PVW: if (t_zero) begin
          bus_rd   <= 1'b1;
          bus_addr <= addr;
          st       <= S_PRD;
        end
        S_PRD: if (bus_rvalid) begin
          if (rd_zero)      st <= addr_last ? S_ESET1 : S_PSET;
          else if (ppc_max) begin
            fault <= FAULT_PREPROG;
            st    <= S_FIN;
          end else          st <= S_PSET;
        end
        S_ESET1: begin
          bus_wr    <= 1'b1;
          bus_wdata <= CMD_ERASE;
          st        <= S_ESET2;
        end
        S_ESET2: begin
          bus_wr    <= 1'b1;
          bus_wdata <= CMD_ERASE;
          st        <= S_EWAIT;
        end
        S_EWAIT: if (t_zero) st <= S_EVC;
        S_EVC: begin
          bus_wr    <= 1'b1;
          bus_wdata <= CMD_ERASE_VFY;
          bus_addr  <= addr;
          st        <= S_EVW;
        end
        S_EVW: if (t_zero) begin
          bus_rd   <= 1'b1;
          bus_addr <= addr;
          st       <= S_ERD;
        end
        S_ERD: if (bus_rvalid) begin
          if (rd_blank)     st <= addr_last ? S_RDMODE : S_EVC;
          else if (epc_max) begin
            fault <= FAULT_ERASE;
            st    <= S_FIN;
          end else          st <= S_ESET1;
        end
        S_RDMODE: begin
          bus_wr    <= 1'b1;
          bus_wdata <= CMD_READ;
          st        <= S_FIN;
        end
        S_FIN: begin
          supply_en <= 1'b0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign err_code = fault;

  // R2: no write reaches the flash without the supply enabled
  p_wr_supply_r2: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> supply_en);
  // R2/R10: completion always coincides with the supply being released
  p_done_release_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !supply_en);
  // R3: write and read strobes never share a cycle
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
  // R9: the reported pulse count stays within the limit
  p_pulse_bound_r9: assert property (@(posedge clk) disable iff (rst)
    pulse_count <= PC_W'(ERASE_MAX));
  // R4: a pre-program fault ends with no erase pulse counted
  p_preprog_nopulse_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && err_code == 2'd1) |-> (pulse_count == '0));
endmodule

// File: tb/flash_chip_eraser_test.sv
module flash_chip_eraser_test;
  localparam int AW = 3;
  localparam int NB = 1 << AW;
  localparam int PMAX = 4;
  localparam int EMAX = 6;
  localparam int TP = 5;
  localparam int TE = 20;
  localparam int TV = 3;
  localparam int PCW = $clog2(EMAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_wr, bus_rd;
  logic [7:0] bus_rdata = 8'h00;
  logic bus_rvalid = 1'b0;
  logic supply_en, done;
  logic [1:0] err_code;
  logic [PCW-1:0] pulse_count;

  always #5 clk = ~clk;

  flash_chip_eraser #(.ADDR_W(AW), .PROG_MAX(PMAX), .ERASE_MAX(EMAX),
    .T_PROG(TP), .T_ERASE(TE), .T_VERIFY(TV)) uut (
    .clk(clk), .rst(rst), .start(start), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .supply_en(supply_en),
    .done(done), .err_code(err_code), .pulse_count(pulse_count));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // flash model state
  int mem [NB];
  int pneed [NB];
  int eneed [NB];
  int pcnt [NB];
  int epulses, n20, last_cyc, gap_need, gap_kind;
  int vaddr, prog_addr, last_va, last_wdata;
  bit prog_armed, prev20;
  int v_r2, v_r3, v_r5, v_r6, v_r7, v_r12;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gap_check();
    if (gap_need > 0 && (cyc - last_cyc) < gap_need) begin
      if (gap_kind == 5) v_r5++;
      else if (gap_kind == 6) v_r6++;
      else v_r12++;
    end
    gap_need = 0;
    last_cyc = cyc;
  endtask

  always @(negedge clk) begin
    bus_rvalid = 1'b0;
    if (bus_wr) begin
      gap_check();
      if (!supply_en) v_r2++;
      last_wdata = bus_wdata;
      if (prog_armed) begin
        prog_armed = 1'b0;
        prev20 = 1'b0;
        if (bus_wdata != 8'h00) v_r3++;
        pcnt[bus_addr]++;
        if (pcnt[bus_addr] >= pneed[bus_addr]) mem[bus_addr] = 0;
        prog_addr = bus_addr;
        gap_need = TP; gap_kind = 12;
      end else if (bus_wdata == 8'h20) begin
        n20++;
        if (prev20) begin
          prev20 = 1'b0;
          epulses++;
          for (int i = 0; i < NB; i++) if (epulses >= eneed[i]) mem[i] = 255;
          gap_need = TE; gap_kind = 5;
        end else begin
          prev20 = 1'b1;
          for (int i = 0; i < NB; i++) if (epulses == 0 && mem[i] != 0) v_r3++;
        end
      end else begin
        prev20 = 1'b0;
        if (bus_wdata == 8'h40) prog_armed = 1'b1;
        else if (bus_wdata == 8'hC0) begin
          vaddr = prog_addr; gap_need = TV; gap_kind = 6;
        end else if (bus_wdata == 8'hA0) begin
          if (int'(bus_addr) < last_va) v_r7++;
          last_va = bus_addr; vaddr = bus_addr;
          gap_need = TV; gap_kind = 6;
        end
      end
    end
    if (bus_rd) begin
      gap_check();
      if (int'(bus_addr) != vaddr) v_r7++;
      bus_rdata = 8'(mem[vaddr]);
      bus_rvalid = 1'b1;
    end
  end

  task automatic set_case(input int k);
    for (int i = 0; i < NB; i++) begin
      pneed[i] = 1;
      eneed[i] = 1;
      mem[i] = 16 + 29 * i;
      pcnt[i] = 0;
    end
    case (k)
      0: ;
      1: for (int i = 0; i < NB; i++) eneed[i] = (i % 6) + 1;
      2: eneed[NB-1] = EMAX;
      3: eneed[3] = EMAX + 1;
      4: eneed[NB-1] = EMAX + 1;
      5: for (int i = 0; i < NB; i++) begin
           pneed[i] = (i % PMAX) + 1;
           eneed[i] = 6 - (i % 6);
         end
      6: pneed[2] = PMAX + 1;
      7: pneed[NB-1] = PMAX + 1;
      default: for (int i = 0; i < NB; i++) begin
           pneed[i] = 1 + ((i * k) % PMAX);
           eneed[i] = 1 + ((i * 3 + k) % EMAX);
         end
    endcase
    epulses = 0; n20 = 0; last_cyc = 0; gap_need = 0; gap_kind = 0;
    vaddr = 0; prog_addr = 0; last_va = 0; last_wdata = -1;
    prog_armed = 1'b0; prev20 = 1'b0;
    v_r2 = 0; v_r3 = 0; v_r5 = 0; v_r6 = 0; v_r7 = 0; v_r12 = 0;
  endtask

  task automatic run_case(input int k);
    int bad, mx, exp_err, exp_p, wd;
    bit ok_all;
    set_case(k);
    bad = -1;
    for (int i = NB - 1; i >= 0; i--) if (pneed[i] > PMAX) bad = i;
    mx = 0;
    for (int i = 0; i < NB; i++) if (eneed[i] > mx) mx = eneed[i];
    if (bad >= 0) begin exp_err = 1; exp_p = 0; end
    else if (mx > EMAX) begin exp_err = 2; exp_p = EMAX; end
    else begin exp_err = 0; exp_p = mx; end

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    chk("R2 watchdog", int'(done), 1);
    chk("R9 err_code", int'(err_code), exp_err);
    chk("R8 pulse_count", int'(pulse_count), exp_p);
    chk("R8 pulses seen", epulses, exp_p);
    chk("R2 supply released", int'(supply_en), 0);
    chk("R2 write w/o supply", v_r2, 0);
    chk("R3 order", v_r3, 0);
    chk("R5 erase wait", v_r5, 0);
    chk("R6 verify wait", v_r6, 0);
    chk("R12 program wait", v_r12, 0);
    chk("R7 verify address", v_r7, 0);
    if (exp_err == 1) begin
      chk("R4 no 20h", n20, 0);
      chk("R4 pulses on bad byte", pcnt[bad], PMAX);
    end else begin
      for (int i = 0; i < NB; i++)
        chk("R3 program pulses", pcnt[i], pneed[i]);
    end
    if (exp_err == 0) begin
      ok_all = 1'b1;
      for (int i = 0; i < NB; i++) if (mem[i] != 255) ok_all = 1'b0;
      chk("R10 all blank", int'(ok_all), 1);
      chk("R10 last write 00h", last_wdata, 0);
      if (k == 2) chk("R11 last byte at limit", int'(err_code), 0);
    end
    if (exp_err == 2) chk("R9 erase 20h writes", n20, 2 * EMAX);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 supply_en", int'(supply_en), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 bus_wr", int'(bus_wr), 0);
    chk("R1 bus_rd", int'(bus_rd), 0);
    chk("R1 err_code", int'(err_code), 0);
    chk("R1 pulse_count", int'(pulse_count), 0);
    for (int k = 0; k < 14; k++) run_case(k);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule